// File: doc/BRIEF.md
# Cascadable Four-Bit Arithmetic-Logic Slice

This block is a purely combinational arithmetic-logic slice. It operates on two four-bit operands and a carry-in, and a three-bit function code chooses one of eight arithmetic or logic operations. The carries inside the slice are computed from per-bit propagate and generate terms by two-level lookahead logic, so no carry ripples from one bit to the next.

The slice also drives group propagate and group generate outputs. An external lookahead unit uses these to form the carry into the next slice, so that several slices can be combined into a wider word without a ripple path between them. The flag outputs are carry-out, sign, overflow and zero. A final multiplexer sends either the ALU result or a bypassed A-register value to the data output.

Top module: `alu_slice`

## Requirements
- R1: When func_i = 3'b000, the ALU result is (r_i + s_i + cin_i) mod 16 and cout_o is bit 4 of that sum.
- R2: When func_i = 3'b001, the ALU result is (s_i + ~r_i + cin_i) mod 16 and cout_o is bit 4 of that sum.
- R3: When func_i = 3'b010, the ALU result is (r_i + ~s_i + cin_i) mod 16 and cout_o is bit 4 of that sum.
- R4: The logic codes produce these results: 3'b011 gives r_i|s_i, 3'b100 gives r_i&s_i, 3'b101 gives ~r_i&s_i, 3'b110 gives r_i^s_i, and 3'b111 gives ~(r_i^s_i).
- R5: The adder operands are x and y. x is ~r_i for codes 001 and 101 and r_i otherwise. y is ~s_i for code 010 and s_i otherwise. gp_o is the AND of (x[i]|y[i]) over all bits. gg_o is the carry out of x + y with a carry-in of 0.
- R6: For every function code, cout_o equals gg_o | (gp_o & cin_i).
- R7: ovf_o is the XOR of the carry into bit 3 and the carry out of bit 3 of x + y + cin_i. For codes 000 and 010 this equals two's-complement overflow.
- R8: sign_o is bit 3 of the ALU result, including when the output selects A.
- R9: zero_o is 1 exactly when the ALU result is 0000, including when the output selects A.
- R10: y_o equals a_i when sel_a_i = 1 and equals the ALU result when sel_a_i = 0.
- R11: Two slices joined by external lookahead, where the upper carry-in is gg_o | gp_o & cin of the lower slice, produce the correct 8-bit sum and carry-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| r_i | input | 4 | First operand |
| s_i | input | 4 | Second operand |
| a_i | input | 4 | A-register value for the output bypass |
| cin_i | input | 1 | Carry-in |
| func_i | input | 3 | Function code |
| sel_a_i | input | 1 | 1 selects a_i onto y_o |
| y_o | output | 4 | Data output |
| cout_o | output | 1 | Carry-out |
| gp_o | output | 1 | Group propagate |
| gg_o | output | 1 | Group generate |
| sign_o | output | 1 | Sign of the ALU result |
| ovf_o | output | 1 | Overflow |
| zero_o | output | 1 | ALU result is zero |

## Verification
The assertions are evaluated whenever an input changes. They check the following: the carry-out agrees with the exported group terms; the bypass path carries a_i; the sign and zero flags agree with the data output whenever the ALU result is selected; and the addition result and its signed overflow agree with a reference. Only the bench can show the remaining behaviour. That covers the exact values for every other function code, that zero and sign still follow the ALU result while A is bypassed, and that two slices combined through group propagate and generate produce a correct wider sum.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;
  typedef enum logic [2:0] {
    FN_ADD   = 3'b000,
    FN_SUBR  = 3'b001,
    FN_SUBS  = 3'b010,
    FN_OR    = 3'b011,
    FN_AND   = 3'b100,
    FN_NOTRS = 3'b101,
    FN_XOR   = 3'b110,
    FN_XNOR  = 3'b111
  } alu_fn_e;
endpackage

// File: rtl/alu_opnd_mod.sv
module alu_opnd_mod
  import alu_slice_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] r_i,
  input  logic [W-1:0] s_i,
  input  alu_fn_e      fn_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic [W-1:0] logic_res_o,
  output logic         is_arith_o
);
  always_comb begin
    x_o = ((fn_i == FN_SUBR) || (fn_i == FN_NOTRS)) ? ~r_i : r_i;
    y_o = (fn_i == FN_SUBS) ? ~s_i : s_i;
    is_arith_o = (fn_i == FN_ADD) || (fn_i == FN_SUBR) || (fn_i == FN_SUBS);
    unique case (fn_i)
      FN_OR:    logic_res_o = r_i | s_i;
      FN_AND:   logic_res_o = r_i & s_i;
      FN_NOTRS: logic_res_o = ~r_i & s_i;
      FN_XOR:   logic_res_o = r_i ^ s_i;
      FN_XNOR:  logic_res_o = ~(r_i ^ s_i);
      default:  logic_res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_cla.sv
module alu_cla #(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W:0]   c_o,
  output logic         gp_o,
  output logic         gg_o
);
  logic [W-1:0] p, g;

  for (genvar b = 0; b < W; b++) begin : g_pg
    assign g[b] = x_i[b] & y_i[b];
    assign p[b] = x_i[b] | y_i[b];
  end

  // Two-level lookahead: each carry is a sum of products of p/g terms
  always_comb begin
    logic t;
    c_o[0] = cin_i;
    for (int i = 1; i <= W; i++) begin
      c_o[i] = 1'b0;
      for (int j = 0; j < i; j++) begin
        t = g[j];
        for (int k = j + 1; k < i; k++) t = t & p[k];
        c_o[i] = c_o[i] | t;
      end
      t = cin_i;
      for (int k = 0; k < i; k++) t = t & p[k];
      c_o[i] = c_o[i] | t;
    end
  end

  always_comb begin
    logic t;
    gg_o = 1'b0;
    for (int j = 0; j < W; j++) begin
      t = g[j];
      for (int k = j + 1; k < W; k++) t = t & p[k];
      gg_o = gg_o | t;
    end
  end

  assign gp_o = &p;
endmodule

// File: rtl/alu_out_mux.sv
module alu_out_mux #(
  parameter int W = 4
) (
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] logic_res_i,
  input  logic         is_arith_i,
  input  logic [W-1:0] a_i,
  input  logic         sel_a_i,
  output logic [W-1:0] alu_res_o,
  output logic [W-1:0] y_o
);
  assign alu_res_o = is_arith_i ? sum_i : logic_res_i;
  assign y_o       = sel_a_i ? a_i : alu_res_o;
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_slice_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] r_i,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  input  logic [2:0]   func_i,
  input  logic         sel_a_i,
  output logic [W-1:0] y_o,
  output logic         cout_o,
  output logic         gp_o,
  output logic         gg_o,
  output logic         sign_o,
  output logic         ovf_o,
  output logic         zero_o
);
  localparam int MSB = W - 1;

  alu_fn_e      fn;
  logic [W-1:0] x, y, logic_res, sum, alu_res;
  logic [W:0]   c;
  logic         is_arith;

  assign fn = alu_fn_e'(func_i);

  alu_opnd_mod #(.W(W)) u_opnd (
    .r_i(r_i), .s_i(s_i), .fn_i(fn),
    .x_o(x), .y_o(y), .logic_res_o(logic_res), .is_arith_o(is_arith)
  );

  alu_cla #(.W(W)) u_cla (
    .x_i(x), .y_i(y), .cin_i(cin_i),
    .c_o(c), .gp_o(gp_o), .gg_o(gg_o)
  );

  assign sum = x ^ y ^ c[W-1:0];

  alu_out_mux #(.W(W)) u_mux (
    .sum_i(sum), .logic_res_i(logic_res), .is_arith_i(is_arith),
    .a_i(a_i), .sel_a_i(sel_a_i),
    .alu_res_o(alu_res), .y_o(y_o)
  );

  assign cout_o = c[W];
  assign ovf_o  = c[MSB] ^ c[W];
  assign sign_o = alu_res[MSB];
  assign zero_o = ~|alu_res;
endmodule

// File: rtl/alu_slice_chk.sv
module alu_slice_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] r_i,
  input logic [W-1:0] s_i,
  input logic [W-1:0] a_i,
  input logic         cin_i,
  input logic [2:0]   func_i,
  input logic         sel_a_i,
  input logic [W-1:0] y_o,
  input logic         cout_o,
  input logic         gp_o,
  input logic         gg_o,
  input logic         sign_o,
  input logic         ovf_o,
  input logic         zero_o
);
  logic [W:0] ref_add;
  assign ref_add = {1'b0, r_i} + {1'b0, s_i} + {{W{1'b0}}, cin_i};

  always_comb begin
    assert_cout_lookahead_R6: assert (cout_o == (gg_o | (gp_o & cin_i)));
    if (sel_a_i) begin
      assert_bypass_a_R10: assert (y_o == a_i);
    end else begin
      assert_sign_msb_R8: assert (sign_o == y_o[W-1]);
      assert_zero_flag_R9: assert (zero_o == (y_o == '0));
      if (func_i == 3'b000) begin
        assert_add_result_R1: assert ({cout_o, y_o} == ref_add);
        assert_add_overflow_R7: assert (ovf_o ==
          ((r_i[W-1] == s_i[W-1]) && (y_o[W-1] != r_i[W-1])));
      end
    end
  end
endmodule

bind alu_slice alu_slice_chk #(.W(W)) chk_i (
  .r_i(r_i), .s_i(s_i), .a_i(a_i), .cin_i(cin_i), .func_i(func_i),
  .sel_a_i(sel_a_i), .y_o(y_o), .cout_o(cout_o), .gp_o(gp_o),
  .gg_o(gg_o), .sign_o(sign_o), .ovf_o(ovf_o), .zero_o(zero_o)
);

// File: tb/alu_slice_tb_top.sv
module alu_slice_tb_top;
  logic       clk = 1'b0;
  logic [3:0] r_i, s_i, a_i;
  logic       cin_i, sel_a_i;
  logic [2:0] func_i;
  logic [3:0] y_o;
  logic       cout_o, gp_o, gg_o, sign_o, ovf_o, zero_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu_slice dut_i (
    .r_i(r_i), .s_i(s_i), .a_i(a_i), .cin_i(cin_i), .func_i(func_i),
    .sel_a_i(sel_a_i), .y_o(y_o), .cout_o(cout_o), .gp_o(gp_o),
    .gg_o(gg_o), .sign_o(sign_o), .ovf_o(ovf_o), .zero_o(zero_o)
  );

  function automatic logic [3:0] op_x(logic [2:0] f, logic [3:0] r);
    return (f == 3'b001 || f == 3'b101) ? ~r : r;
  endfunction
  function automatic logic [3:0] op_y(logic [2:0] f, logic [3:0] s);
    return (f == 3'b010) ? ~s : s;
  endfunction
  function automatic logic [4:0] ref_sum(logic [3:0] x, logic [3:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {4'b0, c};
  endfunction
  function automatic logic [3:0] ref_res(logic [2:0] f, logic [3:0] r, logic [3:0] s, logic c);
    case (f)
      3'b000, 3'b001, 3'b010: return ref_sum(op_x(f, r), op_y(f, s), c)[3:0];
      3'b011: return r | s;
      3'b100: return r & s;
      3'b101: return ~r & s;
      3'b110: return r ^ s;
      default: return ~(r ^ s);
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (f=%b r=%h s=%h c=%b sel=%b)",
               req, act, exp, func_i, r_i, s_i, cin_i, sel_a_i);
    end
  endtask

  task automatic apply(logic [2:0] f, logic [3:0] r, logic [3:0] s,
                       logic [3:0] a, logic c, logic sel);
    @(negedge clk);
    func_i = f; r_i = r; s_i = s; a_i = a; cin_i = c; sel_a_i = sel;
    #1;
  endtask

  task automatic check_vec();
    logic [3:0] x, y, res;
    logic [4:0] sm;
    logic       c3;
    string      rq;
    x   = op_x(func_i, r_i);
    y   = op_y(func_i, s_i);
    sm  = ref_sum(x, y, cin_i);
    c3  = ref_sum({1'b0, x[2:0]}, {1'b0, y[2:0]}, cin_i)[3];
    res = ref_res(func_i, r_i, s_i, cin_i);
    case (func_i)
      3'b000: rq = "R1";
      3'b001: rq = "R2";
      3'b010: rq = "R3";
      default: rq = "R4";
    endcase
    if (sel_a_i) chk("R10 bypass", {4'h0, y_o}, {4'h0, a_i});
    else chk(rq, {4'h0, y_o}, {4'h0, res});
    chk("R1 R2 R3 cout", {7'h0, cout_o}, {7'h0, sm[4]});
    chk("R5 gp", {7'h0, gp_o}, {7'h0, &(x | y)});
    chk("R5 gg", {7'h0, gg_o}, {7'h0, ref_sum(x, y, 1'b0)[4]});
    chk("R6", {7'h0, cout_o}, {7'h0, gg_o | (gp_o & cin_i)});
    chk("R7 ovf", {7'h0, ovf_o}, {7'h0, c3 ^ sm[4]});
    chk("R8 sign", {7'h0, sign_o}, {7'h0, res[3]});
    chk("R9 zero", {7'h0, zero_o}, {7'h0, res == 4'h0});
  endtask

  initial begin
    while (!done && cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] ra, sb, full;
    logic       c0, chi, co_lo;
    logic [3:0] lo;
    void'($urandom(32'd20241));

    // quiescent inputs: zero result
    apply(3'b000, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0);
    chk("R1 idle y", {4'h0, y_o}, 8'h00);
    chk("R9 idle zero", {7'h0, zero_o}, 8'h01);

    // exhaustive sweep
    for (int f = 0; f < 8; f++)
      for (int r = 0; r < 16; r++)
        for (int s = 0; s < 16; s++)
          for (int c = 0; c < 2; c++) begin
            apply(f[2:0], r[3:0], s[3:0], 4'($urandom), c[0], 1'b0);
            check_vec();
            apply(f[2:0], r[3:0], s[3:0], 4'($urandom), c[0], 1'b1);
            check_vec();
          end

    // directed corners: signed overflow on add and R minus S
    apply(3'b000, 4'h7, 4'h1, 4'h0, 1'b0, 1'b0);
    chk("R7 add 7+1", {7'h0, ovf_o}, 8'h01);
    apply(3'b010, 4'h8, 4'h1, 4'h0, 1'b1, 1'b0);
    chk("R7 sub -8-1", {7'h0, ovf_o}, 8'h01);
    // zero follows ALU even with A selected
    apply(3'b100, 4'hA, 4'h5, 4'hF, 1'b0, 1'b1);
    chk("R9 zero under bypass", {7'h0, zero_o}, 8'h01);
    chk("R8 sign under bypass", {7'h0, sign_o}, 8'h00);
    chk("R10 bypass F", {4'h0, y_o}, 8'h0F);

    // R11: two slices joined by external lookahead, random 8-bit adds
    for (int n = 0; n < 300; n++) begin
      ra = 8'($urandom);
      sb = 8'($urandom);
      c0 = 1'($urandom);
      if (n == 0) begin ra = 8'hFF; sb = 8'h00; c0 = 1'b1; end
      apply(3'b000, ra[3:0], sb[3:0], 4'h0, c0, 1'b0);
      lo    = y_o;
      chi   = gg_o | (gp_o & c0);
      apply(3'b000, ra[7:4], sb[7:4], 4'h0, chi, 1'b0);
      co_lo = cout_o;
      full  = {y_o, lo};
      chk("R11 wide sum", full, 8'(ra + sb + c0));
      chk("R11 wide carry", {7'h0, co_lo},
          {7'h0, ({1'b0, ra} + {1'b0, sb} + {8'h0, c0}) > 9'h0FF});
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule